// File: doc/BRIEF.md
# Partial-Array Refresh and Deep Power-Down Controller

This block holds the refresh and low-power state of a pseudo-static RAM. A 3-bit slice code picks the part of the row space that keeps its contents. On each accepted refresh tick the block issues one row address from inside that slice. The row counter walks from the slice's lowest row to its highest row and then starts again at the lowest.

A power-down enable bit, stored active low, arms a deep power-down state. The block enters that state once the chip is deselected. In that state refresh stops and every stored segment is treated as lost. When chip-enable is asserted again, the block leaves the state and re-arms the enable bit by itself. It then holds its ready output low for a fixed initialization wait. The wait is derived from the clock frequency. A register-read port returns either the stored configuration or a fixed identification word. An eight-bit status vector marks each eighth of the array that may have lost its data.

Top module: `psram_refresh_ctrl`

## Requirements
- R1: The slice code (reg bits 2:0) selects the refresh rows as follows, with R = 2^ROW_W rows. Code 000 selects all rows. Codes 001, 010 and 011 select rows from 0 up to R/2-1, R/4-1 and R/8-1. Codes 101, 110 and 111 select rows from R/2, 3R/4 and 7R/8 up to R-1. Every issued row lies in the selected slice.
- R2: With slice code 100, a refresh tick produces no `ref_req`.
- R3: The block accepts a tick when ready is high and power-down is inactive. An accepted tick under a non-empty slice pulses `ref_req` one cycle later and presents `ref_row`. Successive rows count up by one and wrap from the slice's top row to its bottom row.
- R4: The first accepted tick after the slice code changes issues the new slice's lowest row.
- R5: After reset the slice code is 000, the power-down enable bit is 1 (disabled), ready is 1, `pd_active` is 0, `ref_req` is 0 and `seg_valid` is 8'hFF.
- R6: `pd_active` rises one clock after a cycle in which the enable bit is 0 and `ce_n` is 1. While `ce_n` stays 0, a cleared enable bit does not start power-down.
- R7: While `pd_active` is 1, there are no refresh requests, `cfg_wr` is ignored, and `seg_valid` is 0.
- R8: A cycle with `ce_n` = 0 during power-down clears `pd_active` and sets the enable bit back to 1 at the next edge. The slice code is kept.
- R9: After a power-down exit, ready stays low for exactly CLK_MHZ*INIT_US clock cycles. During that wait, ticks and `cfg_wr` are ignored.
- R10: With `reg_sel` = 1, the read data depends on `reg_addr`. Address 01 returns the ID word {row_len_256, version[3:0], density[2:0], generation[2:0], vendor[4:0]}, which is 16'h8965 by default. Address 00 returns the configuration {11'b0, enable bit at bit 4, 1'b0, slice code in bits 2:0}. Other addresses return 0. With `reg_sel` = 0, the read data is 0.
- R11: `seg_valid[i]` covers rows i*R/8 through (i+1)*R/8-1. An accepted tick clears the bit of every eighth outside the slice. Entering power-down clears all eight bits. Only reset sets a bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Bit 4 power-down enable (0 arms), bits 2:0 slice code, bit 3 unused |
| refresh_tick | input | 1 | Refresh interval tick |
| reg_sel | input | 1 | Register-read select |
| reg_addr | input | 2 | Register-read address |
| reg_rdata | output | 16 | Register-read data |
| ref_req | output | 1 | Refresh request pulse |
| ref_row | output | ROW_W | Row to refresh, valid with `ref_req` |
| pd_active | output | 1 | Deep power-down in effect |
| ready | output | 1 | Normal operation allowed |
| seg_valid | output | 8 | Per-eighth retention flags |

## Verification
The assertions check on every cycle that each issued row lies in the slice the code selected, and that code 100 never issues a request. They also check that no request follows a power-down or not-ready cycle, that power-down starts only from an armed and deselected state, and that an exit re-arms the enable bit and drops ready. A further assertion checks that no retention flag ever comes back. Some behaviour only the bench scenarios can show. These include the exact row sequence and its wrap points, the reload to the new base after a code change, and the exact length of the initialization wait. They also include writes being ignored during power-down and the identification and configuration read values.

// File: rtl/psram_refresh_ctrl.sv
`timescale 1ns/1ps
module psram_refresh_ctrl #(
  parameter int ROW_W = 12,
  parameter int CLK_MHZ = 250,
  parameter int INIT_US = 150,
  parameter bit ROW_LEN_256 = 1'b1,
  parameter logic [3:0] VERSION = 4'd1,
  parameter logic [2:0] DENSITY = 3'd1,
  parameter logic [2:0] GEN = 3'd3,
  parameter logic [4:0] VENDOR = 5'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cfg_wr,
  input  logic [4:0]       cfg_wdata,
  input  logic             refresh_tick,
  input  logic             reg_sel,
  input  logic [1:0]       reg_addr,
  output logic [15:0]      reg_rdata,
  output logic             ref_req,
  output logic [ROW_W-1:0] ref_row,
  output logic             pd_active,
  output logic             ready,
  output logic [7:0]       seg_valid
);
  localparam int INIT_CYC = CLK_MHZ * INIT_US;
  localparam int CNT_W = $clog2(INIT_CYC + 1);
  localparam logic [15:0] ID_WORD = {ROW_LEN_256, VERSION, DENSITY, GEN, VENDOR};

  logic [2:0]       par_q, last_par_q;
  logic             pdn_q;
  logic [ROW_W-1:0] cnt_q;
  logic [CNT_W-1:0] init_q;

  logic [ROW_W-1:0] span, lo, hi, pick;
  logic [7:0]       keep;
  logic             accept, do_ref;

  assign span   = {ROW_W{1'b1}} >> par_q[1:0];
  assign lo     = (par_q[2] && par_q[1:0] != 2'd0) ? ~span : '0;
  assign hi     = lo | span;
  assign accept = refresh_tick && ready && !pd_active;
  assign do_ref = accept && (par_q != 3'b100);
  assign pick   = (par_q != last_par_q) ? lo : cnt_q;

  always_comb begin
    case (par_q)
      3'd0: keep = 8'hFF;
      3'd1: keep = 8'h0F;
      3'd2: keep = 8'h03;
      3'd3: keep = 8'h01;
      3'd4: keep = 8'h00;
      3'd5: keep = 8'hF0;
      3'd6: keep = 8'hC0;
      default: keep = 8'h80;
    endcase
  end

  assign reg_rdata = !reg_sel             ? 16'h0000 :
                     (reg_addr == 2'b01)  ? ID_WORD :
                     (reg_addr == 2'b00)  ? {11'b0, pdn_q, 1'b0, par_q} :
                                            16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q      <= 3'd0;
      last_par_q <= 3'd0;
      pdn_q      <= 1'b1;
      cnt_q      <= '0;
      init_q     <= '0;
      ref_req    <= 1'b0;
      ref_row    <= '0;
      pd_active  <= 1'b0;
      ready      <= 1'b1;
      seg_valid  <= 8'hFF;
    end else begin
      ref_req <= do_ref;
      if (do_ref) begin
        ref_row <= pick;
        cnt_q   <= (pick == hi) ? lo : pick + 1'b1;
      end
      if (accept) begin
        last_par_q <= par_q;
        seg_valid  <= seg_valid & keep;
      end
      if (pd_active) begin
        if (!ce_n) begin
          pd_active <= 1'b0;
          pdn_q     <= 1'b1;
          ready     <= 1'b0;
          init_q    <= CNT_W'(INIT_CYC - 1);
        end
      end else begin
        if (cfg_wr && ready) begin
          par_q <= cfg_wdata[2:0];
          pdn_q <= cfg_wdata[4];
        end
        if (!pdn_q && ce_n) begin
          pd_active <= 1'b1;
          seg_valid <= 8'h00;
        end
        if (!ready) begin
          if (init_q == '0) ready <= 1'b1;
          else init_q <= init_q - 1'b1;
        end
      end
    end
  end
endmodule

module psram_refresh_ctrl_chk #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic [2:0]       par,
  input logic             pd_n,
  input logic             ref_req,
  input logic [ROW_W-1:0] ref_row,
  input logic             pd_active,
  input logic             ready,
  input logic [7:0]       seg_valid
);
  function automatic logic in_slice(input logic [ROW_W-1:0] row, input logic [2:0] code);
    logic [ROW_W-1:0] upper;
    int k;
    k = int'(code[1:0]);
    if (k == 0) return code != 3'b100;
    upper = row >> (ROW_W - k);
    if (code[2]) return upper == ROW_W'((1 << k) - 1);
    return upper == '0;
  endfunction

  assert_row_in_slice_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> in_slice(ref_row, $past(par)));
  assert_none_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> ($past(par) != 3'b100));
  assert_entry_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active) |-> $past(!pd_n && ce_n));
  assert_no_ref_in_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |=> !ref_req);
  assert_exit_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_active) |-> (pd_n && !ready));
  assert_init_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !ref_req);
  assert_valid_monotone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid & ~$past(seg_valid)) == 8'h00);
endmodule

bind psram_refresh_ctrl psram_refresh_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .par(par_q), .pd_n(pdn_q),
  .ref_req(ref_req), .ref_row(ref_row), .pd_active(pd_active),
  .ready(ready), .seg_valid(seg_valid)
);

// File: tb/psram_refresh_ctrl_bench.sv
`timescale 1ns/1ps
module psram_refresh_ctrl_bench;
  localparam int ROW_W = 12;
  localparam int INIT_CYC = 250 * 150;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b0, cfg_wr = 1'b0, refresh_tick = 1'b0;
  logic reg_sel = 1'b0;
  logic [1:0] reg_addr = 2'b00;
  logic [4:0] cfg_wdata = 5'h10;
  logic [15:0] reg_rdata;
  logic ref_req, pd_active, ready;
  logic [ROW_W-1:0] ref_row;
  logic [7:0] seg_valid;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  logic [2:0] m_par = 3'd0, m_last = 3'd0;
  logic [ROW_W-1:0] m_cnt = '0;
  logic [7:0] m_mask = 8'hFF;

  always #2 clk = ~clk;

  psram_refresh_ctrl u_psram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .refresh_tick(refresh_tick), .reg_sel(reg_sel), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .ref_req(ref_req), .ref_row(ref_row),
    .pd_active(pd_active), .ready(ready), .seg_valid(seg_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ROW_W-1:0] s_lo(input logic [2:0] c);
    int k = int'(c[1:0]);
    if (!c[2] || k == 0) return '0;
    return ROW_W'((1 << ROW_W) - (1 << (ROW_W - k)));
  endfunction

  function automatic logic [ROW_W-1:0] s_hi(input logic [2:0] c);
    int k = int'(c[1:0]);
    if (c[2] || k == 0) return ROW_W'((1 << ROW_W) - 1);
    return ROW_W'((1 << (ROW_W - k)) - 1);
  endfunction

  function automatic logic [7:0] s_keep(input logic [2:0] c);
    logic [7:0] m = 8'h00;
    if (c == 3'b100) return 8'h00;
    for (int i = 0; i < 8; i++)
      if (i >= int'(s_lo(c) >> (ROW_W - 3)) && i <= int'(s_hi(c) >> (ROW_W - 3))) m[i] = 1'b1;
    return m;
  endfunction

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    reg_sel = 1'b1; reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
    reg_sel = 1'b0;
  endtask

  task automatic step(input logic wr, input logic [4:0] wd, input logic tk, input string tag);
    logic er = 1'b0;
    logic [ROW_W-1:0] erow = '0;
    if (tk) begin
      if (m_par != 3'b100) begin
        er = 1'b1;
        erow = (m_par != m_last) ? s_lo(m_par) : m_cnt;
        m_cnt = (erow == s_hi(m_par)) ? s_lo(m_par) : erow + 1'b1;
      end
      m_last = m_par;
      m_mask = m_mask & s_keep(m_par);
    end
    if (wr) m_par = wd[2:0];
    cfg_wr = wr; cfg_wdata = wd; refresh_tick = tk;
    @(posedge clk); #1;
    cfg_wr = 1'b0; refresh_tick = 1'b0;
    chk(tag, ref_req, er);
    if (er) chk(tag, ref_row, erow);
    chk("R11", seg_valid, m_mask);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R5 ready", ready, 1'b1);
    chk("R5 pd", pd_active, 1'b0);
    chk("R5 req", ref_req, 1'b0);
    chk("R5 seg", seg_valid, 8'hFF);
    rd(2'b00, 16'h0010, "R5 cfg");
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'b01, 16'h8965, "R10 id");
    rd(2'b10, 16'h0000, "R10 other");
    reg_sel = 1'b0; #1;
    chk("R10 nosel", reg_rdata, 16'h0000);

    // full-array sequence then random slices and ticks
    for (int i = 0; i < 20; i++) step(1'b0, 5'h10, 1'b1, "R3");
    for (int i = 0; i < 4000; i++) begin
      logic wr = ($urandom % 16) == 0;
      logic [4:0] wd = {2'b10, 3'($urandom % 8)};
      step(wr, wd, 1'($urandom % 2), "R1 R4");
    end
    rd(2'b00, {11'b0, 1'b1, 1'b0, m_par}, "R10 cfg");

    // wrap directed: bottom 1/8 then top 1/8, then empty slice
    step(1'b1, 5'h13, 1'b0, "R4");
    for (int i = 0; i < 1100; i++) step(1'b0, 5'h13, 1'b1, "R3 wrap bottom");
    step(1'b1, 5'h17, 1'b0, "R4");
    for (int i = 0; i < 1100; i++) step(1'b0, 5'h17, 1'b1, "R3 wrap top");
    step(1'b1, 5'h14, 1'b0, "R2");
    for (int i = 0; i < 10; i++) step(1'b0, 5'h14, 1'b1, "R2");
    step(1'b1, 5'h16, 1'b0, "R4");

    // armed but selected: no power-down
    step(1'b1, 5'h06, 1'b0, "R6");
    for (int i = 0; i < 3; i++) step(1'b0, 5'h06, 1'b0, "R6");
    chk("R6 no entry", pd_active, 1'b0);

    // deselect: enter power-down
    ce_n = 1'b1;
    @(posedge clk); #1;
    chk("R6 entry", pd_active, 1'b1);
    chk("R7 seg", seg_valid, 8'h00);
    cfg_wr = 1'b1; cfg_wdata = 5'h11; refresh_tick = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      chk("R7 noreq", ref_req, 1'b0);
    end
    cfg_wr = 1'b0; refresh_tick = 1'b0;
    rd(2'b00, 16'h0006, "R7 write ignored");

    // exit
    ce_n = 1'b0;
    @(posedge clk); #1;
    chk("R8 exit", pd_active, 1'b0);
    chk("R9 ready low", ready, 1'b0);
    rd(2'b00, 16'h0016, "R8 rearm");
    refresh_tick = 1'b1; cfg_wr = 1'b1; cfg_wdata = 5'h11;
    for (int i = 1; i < INIT_CYC; i++) begin
      @(posedge clk); #1;
      if (ref_req) chk("R9 tick during init", ref_req, 1'b0);
    end
    chk("R9 last wait cycle", ready, 1'b0);
    refresh_tick = 1'b0; cfg_wr = 1'b0;
    rd(2'b00, 16'h0016, "R9 write ignored");
    @(posedge clk); #1;
    chk("R9 ready", ready, 1'b1);
    m_mask = 8'h00;
    for (int i = 0; i < 300; i++)
      step(($urandom % 32) == 0, {2'b10, 3'($urandom % 8)}, 1'($urandom % 2), "R3 R11 after exit");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule